// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Processor Core

This block is a small processor that takes several clocks for each instruction. It has eight general registers of 16 bits, a program counter and an instruction register, all steered by one control state machine. Instructions and data share one synchronous, word-addressed memory. The core reaches that memory through a single address bus, a write-data bus, a read-data bus and separate read and write strobes. Read data returns one clock after the strobe, and the control adds a wait state each time it reads.

Every instruction is one 16-bit word with a 3-bit opcode in bits 15:13. Register-format words (opcode 0) hold rs in 12:10, rt in 9:7, rd in 6:4 and a function code in 3:0. Immediate-format words hold rs in 12:10, rt in 9:7 and a 7-bit two's-complement offset in 6:0. The jump word holds a 13-bit target in 12:0. The opcodes are: 0 register class, 1 load, 2 store, 3 branch-if-equal, 4 add-immediate, 5 jump, 6 no-op and 7 halt.

The control states are ST_INIT, ST_FETCH, ST_FWAIT, ST_DECODE, ST_EXR, ST_ADDI, ST_ADDR, ST_LDREQ, ST_LDWAIT, ST_STORE, ST_BEQ, ST_JUMP and ST_HALT. Their transitions are as follows:
- Reset leads to ST_INIT, and ST_INIT always moves to ST_FETCH.
- ST_FETCH moves to ST_FWAIT, and ST_FWAIT moves to ST_DECODE.
- ST_DECODE branches on the opcode. Opcode 0 goes to ST_EXR, 1 and 2 go to ST_ADDR, 3 goes to ST_BEQ, 4 goes to ST_ADDI, 5 goes to ST_JUMP, 6 goes back to ST_FETCH and 7 goes to ST_HALT.
- ST_ADDR goes to ST_LDREQ for a load and to ST_STORE for a store. ST_LDREQ goes to ST_LDWAIT.
- ST_EXR, ST_ADDI, ST_BEQ, ST_JUMP, ST_LDWAIT and ST_STORE all return to ST_FETCH.
- ST_HALT stays in ST_HALT until reset.

Top module: `cpu16_core`

## Requirements
- R1: Reset clears all eight registers and the program counter, and deasserts `halted`. After reset the first instruction read is at address 0.
- R2: During fetch, the core presents the program counter with a one-cycle read strobe. It latches the returned word one clock later, and the ALU adds 1 to the program counter. A program with no control-flow instructions therefore reads consecutive addresses.
- R3: For opcode 0, function codes 0, 1, 2 and 3 write rs+rt, rs-rt, rs AND rt and rs OR rt into rd. The sum and difference wrap modulo 2^16.
- R4: Opcode 0 with function 4 writes 1 into rd when rs is less than rt as signed 16-bit values, and writes 0 otherwise.
- R5: Opcode 0 with a function code from 5 to 15 leaves every register unchanged.
- R6: Opcode 1 loads rt from memory at rs plus the sign-extended 7-bit offset. The load leaves memory unchanged.
- R7: Opcode 2 writes rt to memory at rs plus the sign-extended offset, using a write strobe that lasts one cycle.
- R8: Opcode 4 writes rs plus the sign-extended offset into rt. Register r0 is an ordinary register and can be written.
- R9: Opcode 3 compares rs and rt. When they are equal, it adds the sign-extended offset (forward or backward) to the already-incremented program counter. When they differ, execution continues at the next word.
- R10: Opcode 5 loads the program counter with the 13-bit target, zero-extended.
- R11: Opcode 7 raises `halted` and holds it until reset. While halted, neither memory strobe is asserted.
- R12: Opcode 6 changes no register and no memory location, and execution continues with the next word.
- R13: The read and write strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address for instruction or data access |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid one clock after a read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High while the halt state holds the core |

## Verification
The strobe properties assume that the memory answers exactly one clock after a read strobe and never needs stall cycles, because the control has no ready input and latches whatever arrives. The properties also assume that reset is held across at least one rising edge. The bench models a memory that registers its output on the strobe edge with a fixed latency of one cycle. It holds reset for several cycles. Its program keeps every address inside the 256-word modelled array, so no access aliases onto the code region.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int XLEN   = 16;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OP_W   = 3;
    localparam int FN_W   = 4;
    localparam int IMM_W  = 7;
    localparam int TGT_W  = 13;

    typedef enum logic [OP_W-1:0] {
        OP_REG  = 3'd0,
        OP_LW   = 3'd1,
        OP_SW   = 3'd2,
        OP_BEQ  = 3'd3,
        OP_ADDI = 3'd4,
        OP_J    = 3'd5,
        OP_NOP  = 3'd6,
        OP_HALT = 3'd7
    } opcode_e;

    typedef enum logic [3:0] {
        ST_INIT, ST_FETCH, ST_FWAIT, ST_DECODE, ST_EXR, ST_ADDI, ST_ADDR,
        ST_LDREQ, ST_LDWAIT, ST_STORE, ST_BEQ, ST_JUMP, ST_HALT
    } cpu_state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef enum logic {ASEL_PC, ASEL_RS} asel_e;
    typedef enum logic [1:0] {BSEL_RT, BSEL_ONE, BSEL_IMM} bsel_e;

    typedef struct packed {
        logic    mem_rd;
        logic    mem_wr;
        logic    addr_ea;     // 1: effective address drives memory
        logic    ir_ld;
        logic    pc_ld_alu;
        logic    pc_ld_tgt;
        logic    ab_ld;
        logic    ea_ld;
        logic    rf_we;
        logic    dst_rt;      // 1: write rt field, 0: write rd field
        logic    wb_mem;      // 1: write-back from memory data
        alu_op_e alu_op;
        asel_e   asel;
        bsel_e   bsel;
        logic    halted;
    } ctrl_t;

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && waddr == AW'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
    import cpu16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    input  logic            ops_equal,
    output ctrl_t           ctl
);

    cpu_state_e state, state_nx;
    opcode_e    op;

    assign op = opcode_e'(opcode);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INIT;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:   state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_FWAIT;
            ST_FWAIT:  state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (op)
                    OP_REG:        state_nx = ST_EXR;
                    OP_LW, OP_SW:  state_nx = ST_ADDR;
                    OP_BEQ:        state_nx = ST_BEQ;
                    OP_ADDI:       state_nx = ST_ADDI;
                    OP_J:          state_nx = ST_JUMP;
                    OP_NOP:        state_nx = ST_FETCH;
                    OP_HALT:       state_nx = ST_HALT;
                    default:       state_nx = ST_FETCH;
                endcase
            end
            ST_ADDR:   state_nx = (op == OP_LW) ? ST_LDREQ : ST_STORE;
            ST_LDREQ:  state_nx = ST_LDWAIT;
            ST_EXR, ST_ADDI, ST_BEQ, ST_JUMP, ST_LDWAIT, ST_STORE:
                       state_nx = ST_FETCH;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_INIT;
        endcase
    end

    // output logic
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        ctl.asel   = ASEL_PC;
        ctl.bsel   = BSEL_ONE;
        unique case (state)
            ST_FETCH: begin
                ctl.mem_rd = 1'b1;
            end
            ST_FWAIT: begin
                ctl.ir_ld     = 1'b1;
                ctl.pc_ld_alu = 1'b1;
            end
            ST_DECODE: begin
                ctl.ab_ld = 1'b1;
            end
            ST_EXR: begin
                ctl.asel = ASEL_RS;
                ctl.bsel = BSEL_RT;
                ctl.rf_we = 1'b1;
                unique case (funct)
                    4'd0:    ctl.alu_op = ALU_ADD;
                    4'd1:    ctl.alu_op = ALU_SUB;
                    4'd2:    ctl.alu_op = ALU_AND;
                    4'd3:    ctl.alu_op = ALU_OR;
                    4'd4:    ctl.alu_op = ALU_SLT;
                    default: ctl.rf_we  = 1'b0;
                endcase
            end
            ST_ADDI: begin
                ctl.asel   = ASEL_RS;
                ctl.bsel   = BSEL_IMM;
                ctl.rf_we  = 1'b1;
                ctl.dst_rt = 1'b1;
            end
            ST_ADDR: begin
                ctl.asel  = ASEL_RS;
                ctl.bsel  = BSEL_IMM;
                ctl.ea_ld = 1'b1;
            end
            ST_LDREQ: begin
                ctl.mem_rd  = 1'b1;
                ctl.addr_ea = 1'b1;
            end
            ST_LDWAIT: begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rt = 1'b1;
                ctl.wb_mem = 1'b1;
            end
            ST_STORE: begin
                ctl.mem_wr  = 1'b1;
                ctl.addr_ea = 1'b1;
            end
            ST_BEQ: begin
                ctl.bsel      = BSEL_IMM;
                ctl.pc_ld_alu = ops_equal;
            end
            ST_JUMP: begin
                ctl.pc_ld_tgt = 1'b1;
            end
            ST_HALT: begin
                ctl.halted = 1'b1;
            end
            default: begin
                ctl.halted = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            halted
);

    ctrl_t             ctl;
    logic [XLEN-1:0]   pc_q, ir_q, a_q, b_q, ea_q;
    logic [XLEN-1:0]   rf_a, rf_b, alu_a, alu_b, alu_y, imm_sx, wb_data;
    logic [RIDX_W-1:0] rs_f, rt_f, rd_f, wr_idx;

    assign rs_f   = ir_q[12:10];
    assign rt_f   = ir_q[9:7];
    assign rd_f   = ir_q[6:4];
    assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

    cpu16_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (ir_q[15:13]),
        .funct     (ir_q[FN_W-1:0]),
        .ops_equal (a_q == b_q),
        .ctl       (ctl)
    );

    assign alu_a = (ctl.asel == ASEL_PC) ? pc_q : a_q;

    always_comb begin
        unique case (ctl.bsel)
            BSEL_RT:  alu_b = b_q;
            BSEL_IMM: alu_b = imm_sx;
            default:  alu_b = XLEN'(1);
        endcase
    end

    cpu16_alu #(.W(XLEN)) u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    assign wr_idx  = ctl.dst_rt ? rt_f : rd_f;
    assign wb_data = ctl.wb_mem ? mem_rdata : alu_y;

    cpu16_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.rf_we),
        .waddr   (wr_idx),
        .wdata   (wb_data),
        .raddr_a (rs_f),
        .raddr_b (rt_f),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            ea_q <= '0;
        end else begin
            if (ctl.pc_ld_tgt) begin
                pc_q <= {{(XLEN-TGT_W){1'b0}}, ir_q[TGT_W-1:0]};
            end else if (ctl.pc_ld_alu) begin
                pc_q <= alu_y;
            end
            if (ctl.ir_ld) ir_q <= mem_rdata;
            if (ctl.ab_ld) begin
                a_q <= rf_a;
                b_q <= rf_b;
            end
            if (ctl.ea_ld) ea_q <= alu_y;
        end
    end

    assign mem_addr  = ctl.addr_ea ? ea_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign halted    = ctl.halted;

endmodule

// File: rtl/cpu16_chk.sv
module cpu16_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd,
    input logic mem_wr,
    input logic halted
);

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

endmodule

bind cpu16_core cpu16_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
);

// File: tb/sim_cpu16_core.sv
module sim_cpu16_core;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 256;
    localparam int N_EXP      = 12;
    localparam int BASE       = 128;

    // {tag number, address, expected word}
    localparam logic [39:0] EXPECT [N_EXP] = '{
        {8'd3,  16'd128, 16'h0002},   // R3 add 5 + -3
        {8'd3,  16'd129, 16'h0008},   // R3 sub 5 - -3
        {8'd3,  16'd130, 16'h0005},   // R3 and
        {8'd3,  16'd131, 16'hFFFD},   // R3 or
        {8'd4,  16'd132, 16'h0001},   // R4 slt -3 < 5
        {8'd4,  16'd133, 16'h0000},   // R4 slt 5 < -3
        {8'd5,  16'd134, 16'h0009},   // R5 funct 7 writes nothing
        {8'd6,  16'd135, 16'h1234},   // R6 load with negative offset
        {8'd8,  16'd136, 16'h0007},   // R8 r0 writable
        {8'd9,  16'd137, 16'h0003},   // R9 taken skips, not-taken falls through
        {8'd10, 16'd138, 16'h0003},   // R10 R12 jump target, no-op harmless
        {8'd9,  16'd139, 16'h0005}    // R9 backward loop count
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, halted;
    logic [15:0] mem [MEM_WORDS];
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu16_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    function automatic logic [15:0] enc_r(input logic [2:0] rs, input logic [2:0] rt,
                                          input logic [2:0] rd, input logic [3:0] fn);
        return {3'd0, rs, rt, rd, fn};
    endfunction

    function automatic logic [15:0] enc_i(input logic [2:0] op, input logic [2:0] rs,
                                          input logic [2:0] rt, input logic [6:0] off);
        return {op, rs, rt, off};
    endfunction

    function automatic logic [15:0] enc_j(input logic [12:0] tgt);
        return {3'd5, tgt};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_program();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'h0000;
        mem[127] = 16'h1234;
        mem[0]  = enc_i(3'd4, 3'd0, 3'd1, 7'd5);
        mem[1]  = enc_i(3'd4, 3'd0, 3'd2, 7'h7D);
        mem[2]  = enc_i(3'd4, 3'd0, 3'd7, 7'd32);
        mem[3]  = enc_r(3'd7, 3'd7, 3'd7, 4'd0);
        mem[4]  = enc_r(3'd7, 3'd7, 3'd7, 4'd0);
        mem[5]  = enc_r(3'd1, 3'd2, 3'd3, 4'd0);
        mem[6]  = enc_i(3'd2, 3'd7, 3'd3, 7'd0);
        mem[7]  = enc_r(3'd1, 3'd2, 3'd3, 4'd1);
        mem[8]  = enc_i(3'd2, 3'd7, 3'd3, 7'd1);
        mem[9]  = enc_r(3'd1, 3'd2, 3'd3, 4'd2);
        mem[10] = enc_i(3'd2, 3'd7, 3'd3, 7'd2);
        mem[11] = enc_r(3'd1, 3'd2, 3'd3, 4'd3);
        mem[12] = enc_i(3'd2, 3'd7, 3'd3, 7'd3);
        mem[13] = enc_r(3'd2, 3'd1, 3'd3, 4'd4);
        mem[14] = enc_i(3'd2, 3'd7, 3'd3, 7'd4);
        mem[15] = enc_r(3'd1, 3'd2, 3'd3, 4'd4);
        mem[16] = enc_i(3'd2, 3'd7, 3'd3, 7'd5);
        mem[17] = enc_i(3'd4, 3'd0, 3'd4, 7'd9);
        mem[18] = enc_r(3'd1, 3'd2, 3'd4, 4'd7);
        mem[19] = enc_i(3'd2, 3'd7, 3'd4, 7'd6);
        mem[20] = enc_i(3'd1, 3'd7, 3'd5, 7'h7F);
        mem[21] = enc_i(3'd2, 3'd7, 3'd5, 7'd7);
        mem[22] = enc_i(3'd4, 3'd0, 3'd0, 7'd7);
        mem[23] = enc_i(3'd2, 3'd7, 3'd0, 7'd8);
        mem[24] = enc_i(3'd3, 3'd1, 3'd1, 7'd2);
        mem[25] = enc_i(3'd4, 3'd0, 3'd6, 7'd11);
        mem[26] = enc_i(3'd4, 3'd0, 3'd6, 7'd22);
        mem[27] = enc_i(3'd3, 3'd1, 3'd2, 7'd1);
        mem[28] = enc_i(3'd4, 3'd6, 3'd6, 7'd3);
        mem[29] = enc_i(3'd2, 3'd7, 3'd6, 7'd9);
        mem[30] = {3'd6, 13'h1FFF};
        mem[31] = enc_j(13'd40);
        mem[32] = enc_i(3'd4, 3'd0, 3'd6, 7'd1);
        mem[40] = enc_i(3'd2, 3'd7, 3'd6, 7'd10);
        mem[41] = enc_i(3'd4, 3'd0, 3'd5, 7'h79);
        mem[42] = enc_i(3'd4, 3'd5, 3'd5, 7'd1);
        mem[43] = enc_r(3'd5, 3'd1, 3'd6, 4'd4);
        mem[44] = enc_i(3'd4, 3'd0, 3'd3, 7'h7A);
        mem[45] = enc_i(3'd3, 3'd6, 3'd3, 7'h7C);
        mem[46] = enc_i(3'd2, 3'd7, 3'd5, 7'd11);
        mem[47] = {3'd7, 13'd0};
        mem[48] = enc_i(3'd4, 3'd0, 3'd5, 7'd0);
    endtask

    task automatic wait_halt();
        int cyc = 0;
        while (!halted && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check("R11 halt reached", 16'(halted), 16'd1);
    endtask

    task automatic walk_table();
        for (int k = 0; k < N_EXP; k++) begin
            check($sformatf("R%0d mem[%0d]", EXPECT[k][39:32], EXPECT[k][31:16]),
                  mem[EXPECT[k][23:16]], EXPECT[k][15:0]);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        int quiet_hits;
        int cyc;
        rst_n = 1'b0;
        load_program();
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 halted low in reset", 16'(halted), 16'd0);
        check("R1 no write in reset", 16'(mem_wr), 16'd0);
        rst_n = 1'b1;

        // R1 first fetch at 0, R2 next fetch at 1
        cyc = 0;
        while (!mem_rd && cyc < 20) begin @(negedge clk); cyc++; end
        check("R1 first fetch address", mem_addr, 16'd0);
        @(negedge clk);
        cyc = 0;
        while (!mem_rd && cyc < 20) begin @(negedge clk); cyc++; end
        check("R2 second fetch address", mem_addr, 16'd1);

        wait_halt();
        walk_table();
        check("R6 load source untouched", mem[127], 16'h1234);
        check("R12 no store below data area", mem[BASE-2], 16'h0000);

        // R11 quiet and sticky while halted
        quiet_hits = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || !halted) quiet_hits++;
        end
        check("R11 halted stays quiet", 16'(quiet_hits), 16'd0);

        // R1 reset releases halt, program reruns from scratch
        rst_n = 1'b0;
        for (int i = BASE; i < BASE + 16; i++) mem[i] = 16'h0000;
        @(negedge clk);
        check("R1 reset clears halted", 16'(halted), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_halt();
        walk_table();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule